// File: doc/BRIEF.md
# Burst Address Sequencer

This block sits in front of a synchronous pipelined memory array and turns the per-clock control pins into an array address and a cycle classification. On a strobe-initiated start it captures an external address; the two least significant bits then step through a four-beat burst under control of an advance input, while the upper bits stay put until the next start.

Two start strobes exist with different rules. The processor-side strobe always starts a read and is gated by the first chip select alone. The controller-side strobe only takes effect when the processor-side strobe is not acting, and it samples the write indication on its own edge to pick a read or a write burst. A static order input picks linear or interleaved stepping of the low two bits. All outputs are registered and reflect the inputs sampled at the previous rising clock edge.

Top module: `burst_addr_ctrl`

## Requirements
- R1: While `rst` is high at a rising edge, the block clears: `cycle_o` becomes 0 (deselect), `burst_active_o` becomes 0 and `mem_addr_o` becomes 0.
- R2: The device counts as selected only when `sel_a_n` is 0, `sel_b` is 1 and `sel_c_n` is 0. If a start is requested (`ctrl_strobe_n` low, or `proc_strobe_n` low with `sel_a_n` low) while not selected, the cycle is deselect (code 0) and `burst_active_o` drops to 0.
- R3: With `sel_a_n` high the processor strobe has no effect: with `ctrl_strobe_n` high the cycle is continue or suspend as set by `advance_n`, and the external address is not loaded.
- R4: `proc_strobe_n` low with the device selected gives begin-read (code 1), loads `addr_i`, and sets `burst_active_o`, whatever `write_n`, `ctrl_strobe_n` and `advance_n` are.
- R5: `ctrl_strobe_n` low, `proc_strobe_n` high and the device selected loads `addr_i`, sets `burst_active_o` and gives begin-write (code 2) when `write_n` is 0, begin-read (code 1) when `write_n` is 1.
- R6: With both strobes inactive and `advance_n` low the cycle is continue (code 3); during an active burst the address moves to the next beat, with no burst active the address is unchanged.
- R7: With both strobes inactive and `advance_n` high the cycle is suspend (code 4) and `mem_addr_o` is unchanged.
- R8: With `order_i` = 0 the low two address bits equal (start + beat) mod 4, e.g. start 01 gives 01, 10, 11, 00.
- R9: With `order_i` = 1 the low two address bits equal start XOR beat, e.g. start 01 gives 01, 00, 11, 10.
- R10: After four advances the low bits return to the loaded start value, and the bits above bit 1 never change except on a load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| sel_a_n | input | 1 | First chip select, active low; also gates the processor strobe |
| sel_b | input | 1 | Second chip select, active high |
| sel_c_n | input | 1 | Third chip select, active low |
| proc_strobe_n | input | 1 | Processor-side address strobe, active low |
| ctrl_strobe_n | input | 1 | Controller-side address strobe, active low |
| advance_n | input | 1 | Burst advance, active low |
| write_n | input | 1 | Write indication, active low, sampled with the controller strobe |
| order_i | input | 1 | Static burst order: 0 linear, 1 interleaved |
| addr_i | input | ADDR_W | External start address |
| mem_addr_o | output | ADDR_W | Current array address |
| cycle_o | output | 3 | Cycle code: 0 deselect, 1 begin read, 2 begin write, 3 continue, 4 suspend |
| burst_active_o | output | 1 | A burst has been started and not ended by a deselect |

## Verification
The embedded properties watch, on every clock, that a deselect code never coexists with an active burst, that begin codes always mean an active burst, that suspend holds the address, that a high first select keeps the processor strobe from starting anything, that a controller write start yields the write code, and that the upper address and beat counter move only when loading or stepping. What they cannot show is the actual beat order in each mode, the wrap back to the start value after four beats, and the precedence of the processor strobe over the controller strobe with a concrete address; the directed scenarios compare those address sequences against values worked out from the requirements.

// File: rtl/bac_pkg.sv
package bac_pkg;

    localparam int BEAT_W   = 2;
    localparam int CYC_W    = 3;

    typedef enum logic [CYC_W-1:0] {
        CYC_DESEL = 3'd0,
        CYC_BRD   = 3'd1,
        CYC_BWR   = 3'd2,
        CYC_CONT  = 3'd3,
        CYC_SUSP  = 3'd4
    } cyc_e;

    typedef struct packed {
        cyc_e kind;
        logic load;
        logic step;
    } decode_s;

    function automatic logic [BEAT_W-1:0] beat_offset(
        input logic [BEAT_W-1:0] base,
        input logic [BEAT_W-1:0] beat,
        input logic              interleave
    );
        logic [BEAT_W-1:0] r;
        if (interleave) r = base ^ beat;
        else            r = base + beat;
        return r;
    endfunction

endpackage

// File: rtl/bac_cycle_decode.sv
module bac_cycle_decode
    import bac_pkg::*;
(
    input  logic    sel_a_n,
    input  logic    sel_b,
    input  logic    sel_c_n,
    input  logic    proc_strobe_n,
    input  logic    ctrl_strobe_n,
    input  logic    advance_n,
    input  logic    write_n,
    output decode_s dec_o
);

    logic selected;
    logic proc_go;
    logic ctrl_go;

    always_comb begin
        selected = !sel_a_n && sel_b && !sel_c_n;
        proc_go  = !proc_strobe_n && !sel_a_n;
        ctrl_go  = !ctrl_strobe_n;

        dec_o.kind = CYC_SUSP;
        dec_o.load = 1'b0;
        dec_o.step = 1'b0;

        if (proc_go || ctrl_go) begin
            if (!selected) begin
                dec_o.kind = CYC_DESEL;
            end else if (proc_go) begin
                dec_o.kind = CYC_BRD;
                dec_o.load = 1'b1;
            end else begin
                dec_o.kind = write_n ? CYC_BRD : CYC_BWR;
                dec_o.load = 1'b1;
            end
        end else if (!advance_n) begin
            dec_o.kind = CYC_CONT;
            dec_o.step = 1'b1;
        end
    end

endmodule

// File: rtl/bac_burst_counter.sv
module bac_burst_counter
    import bac_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              step,
    input  logic [BEAT_W-1:0] base_in,
    input  logic              interleave,
    output logic [BEAT_W-1:0] low_o
);

    logic [BEAT_W-1:0] base_q;
    logic [BEAT_W-1:0] beat_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q <= '0;
            beat_q <= '0;
        end else if (load) begin
            base_q <= base_in;
            beat_q <= '0;
        end else if (step) begin
            beat_q <= beat_q + 1'b1;
        end
    end

    assign low_o = beat_offset(base_q, beat_q, interleave);

    // R6 / R10: a step advances the beat by one, modulo four
    a_r6_beat_steps: assert property (@(posedge clk) disable iff (rst)
        (step && !load) |=> (beat_q == $past(beat_q) + 2'd1));

    // R7: without load or step the burst position is frozen
    a_r7_beat_frozen: assert property (@(posedge clk) disable iff (rst)
        (!step && !load) |=> ($stable(beat_q) && $stable(base_q)));

endmodule

// File: rtl/bac_addr_reg.sv
module bac_addr_reg #(
    parameter int UP_W = 18
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            load,
    input  logic [UP_W-1:0] upper_in,
    output logic [UP_W-1:0] upper_o
);

    always_ff @(posedge clk) begin
        if (rst)       upper_o <= '0;
        else if (load) upper_o <= upper_in;
    end

    // R10: upper bits change only on a load
    a_r10_upper_held: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(upper_o));

endmodule

// File: rtl/burst_addr_ctrl.sv
module burst_addr_ctrl
    import bac_pkg::*;
#(
    parameter int ADDR_W = 20
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sel_a_n,
    input  logic              sel_b,
    input  logic              sel_c_n,
    input  logic              proc_strobe_n,
    input  logic              ctrl_strobe_n,
    input  logic              advance_n,
    input  logic              write_n,
    input  logic              order_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [2:0]        cycle_o,
    output logic              burst_active_o
);

    localparam int UP_W = ADDR_W - BEAT_W;

    decode_s           dec;
    cyc_e              cycle_q;
    logic              active_q;
    logic              step_en;
    logic [BEAT_W-1:0] low_bits;
    logic [UP_W-1:0]   up_bits;

    bac_cycle_decode u_dec (
        .sel_a_n       (sel_a_n),
        .sel_b         (sel_b),
        .sel_c_n       (sel_c_n),
        .proc_strobe_n (proc_strobe_n),
        .ctrl_strobe_n (ctrl_strobe_n),
        .advance_n     (advance_n),
        .write_n       (write_n),
        .dec_o         (dec)
    );

    assign step_en = dec.step && active_q;

    bac_burst_counter u_cnt (
        .clk        (clk),
        .rst        (rst),
        .load       (dec.load),
        .step       (step_en),
        .base_in    (addr_i[BEAT_W-1:0]),
        .interleave (order_i),
        .low_o      (low_bits)
    );

    bac_addr_reg #(.UP_W(UP_W)) u_up (
        .clk      (clk),
        .rst      (rst),
        .load     (dec.load),
        .upper_in (addr_i[ADDR_W-1:BEAT_W]),
        .upper_o  (up_bits)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cycle_q  <= CYC_DESEL;
            active_q <= 1'b0;
        end else begin
            cycle_q <= dec.kind;
            if (dec.load)                    active_q <= 1'b1;
            else if (dec.kind == CYC_DESEL)  active_q <= 1'b0;
        end
    end

    assign mem_addr_o     = {up_bits, low_bits};
    assign cycle_o        = cycle_q;
    assign burst_active_o = active_q;

    // R2: a deselect cycle always ends the burst
    a_r2_desel_idle: assert property (@(posedge clk) disable iff (rst)
        (cycle_o == 3'd0) |-> !burst_active_o);

    // R4 / R5: a begin cycle always leaves a burst active
    a_r4_begin_active: assert property (@(posedge clk) disable iff (rst)
        (cycle_o == 3'd1 || cycle_o == 3'd2) |-> burst_active_o);

    // R3: first select high blocks the processor strobe
    a_r3_proc_blocked: assert property (@(posedge clk) disable iff (rst)
        (sel_a_n && ctrl_strobe_n) |=> (cycle_o == 3'd3 || cycle_o == 3'd4));

    // R5: controller strobe with write low starts a write burst
    a_r5_ctrl_write: assert property (@(posedge clk) disable iff (rst)
        (!ctrl_strobe_n && proc_strobe_n && !sel_a_n && sel_b && !sel_c_n && !write_n)
        |=> (cycle_o == 3'd2));

    // R7: suspend keeps the array address
    a_r7_suspend_hold: assert property (@(posedge clk) disable iff (rst)
        (cycle_o == 3'd4) |-> (mem_addr_o == $past(mem_addr_o)));

endmodule

// File: tb/burst_addr_ctrl_test.sv
module burst_addr_ctrl_test;

    localparam int AW = 20;

    logic          clk = 1'b0;
    logic          rst;
    logic          sel_a_n, sel_b, sel_c_n;
    logic          proc_strobe_n, ctrl_strobe_n, advance_n, write_n, order_i;
    logic [AW-1:0] addr_i;
    logic [AW-1:0] mem_addr_o;
    logic [2:0]    cycle_o;
    logic          burst_active_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    localparam logic [2:0] DESEL = 3'd0, BRD = 3'd1, BWR = 3'd2, CONT = 3'd3, SUSP = 3'd4;

    burst_addr_ctrl #(.ADDR_W(AW)) uut (
        .clk            (clk),
        .rst            (rst),
        .sel_a_n        (sel_a_n),
        .sel_b          (sel_b),
        .sel_c_n        (sel_c_n),
        .proc_strobe_n  (proc_strobe_n),
        .ctrl_strobe_n  (ctrl_strobe_n),
        .advance_n      (advance_n),
        .write_n        (write_n),
        .order_i        (order_i),
        .addr_i         (addr_i),
        .mem_addr_o     (mem_addr_o),
        .cycle_o        (cycle_o),
        .burst_active_o (burst_active_o)
    );

    always #5 clk = ~clk;

    function automatic logic [AW-1:0] exp_addr(input logic [AW-1:0] start,
                                               input int beat, input logic il);
        logic [1:0] b;
        b = beat[1:0];
        return {start[AW-1:2], il ? (start[1:0] ^ b) : (start[1:0] + b)};
    endfunction

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic drive(input logic a_n, input logic b, input logic c_n,
                         input logic ps_n, input logic cs_n, input logic adv_n,
                         input logic wr_n, input logic [AW-1:0] a);
        sel_a_n = a_n; sel_b = b; sel_c_n = c_n;
        proc_strobe_n = ps_n; ctrl_strobe_n = cs_n;
        advance_n = adv_n; write_n = wr_n; addr_i = a;
    endtask

    task automatic chk(input string req, input logic [2:0] ecyc,
                       input logic eact, input bit use_addr, input logic [AW-1:0] eaddr);
        n_checks++;
        if (cycle_o !== ecyc || burst_active_o !== eact ||
            (use_addr && mem_addr_o !== eaddr)) begin
            n_fail++;
            $display("FAIL %s: cycle=%0d act=%0b addr=%h expected cycle=%0d act=%0b addr=%h",
                     req, cycle_o, burst_active_o, mem_addr_o, ecyc, eact, eaddr);
        end
    endtask

    task automatic t_reset();
        rst = 1'b1; order_i = 1'b0;
        drive(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 20'hFFFFF);
        tick(); tick();
        chk("R1 reset", DESEL, 1'b0, 1'b1, '0);
        rst = 1'b0;
    endtask

    task automatic t_proc_read_linear();
        logic [AW-1:0] st;
        st = 20'hABCD5;
        order_i = 1'b0;
        drive(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, st);
        tick();
        chk("R4 proc strobe begins read", BRD, 1'b1, 1'b1, st);
        drive(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 20'h00000);
        tick(); chk("R8 linear beat1", CONT, 1'b1, 1'b1, exp_addr(st, 1, 1'b0));
        tick(); chk("R8 linear beat2", CONT, 1'b1, 1'b1, exp_addr(st, 2, 1'b0));
        advance_n = 1'b1;
        tick(); chk("R7 suspend holds", SUSP, 1'b1, 1'b1, exp_addr(st, 2, 1'b0));
        advance_n = 1'b0;
        tick(); chk("R8 linear beat3", CONT, 1'b1, 1'b1, exp_addr(st, 3, 1'b0));
        tick(); chk("R10 linear wrap", CONT, 1'b1, 1'b1, st);
    endtask

    task automatic t_interleave();
        logic [AW-1:0] st;
        st = 20'h5A3B1;
        order_i = 1'b1;
        drive(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, st);
        tick();
        chk("R4 load interleave", BRD, 1'b1, 1'b1, st);
        drive(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 20'h12340);
        for (int k = 1; k <= 3; k++) begin
            tick(); chk("R9 interleave beat", CONT, 1'b1, 1'b1, exp_addr(st, k, 1'b1));
        end
        tick(); chk("R10 interleave wrap", CONT, 1'b1, 1'b1, st);
        st = 20'h0F00B;
        drive(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, st);
        tick(); chk("R9 load start 11", BRD, 1'b1, 1'b1, st);
        advance_n = 1'b0; proc_strobe_n = 1'b1;
        tick(); chk("R9 start 11 beat1", CONT, 1'b1, 1'b1, 20'h0F00A);
        tick(); chk("R9 start 11 beat2", CONT, 1'b1, 1'b1, 20'h0F009);
    endtask

    task automatic t_ctrl_strobe();
        order_i = 1'b0;
        drive(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 20'h00F02);
        tick(); chk("R5 ctrl write", BWR, 1'b1, 1'b1, 20'h00F02);
        drive(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 20'h00F03);
        tick(); chk("R5 ctrl read", BRD, 1'b1, 1'b1, 20'h00F03);
    endtask

    task automatic t_sel_a_block();
        drive(1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 20'h77770);
        tick(); chk("R3 proc strobe blocked, continue", CONT, 1'b1, 1'b1, 20'h00F00);
        advance_n = 1'b1;
        tick(); chk("R3 proc strobe blocked, suspend", SUSP, 1'b1, 1'b1, 20'h00F00);
    endtask

    task automatic t_deselect();
        drive(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 20'h11111);
        tick(); chk("R2 sel_b low deselects", DESEL, 1'b0, 1'b0, '0);
        drive(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 20'h22222);
        tick(); chk("R6 continue with no burst holds address", CONT, 1'b0, 1'b1, 20'h00F00);
        drive(1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 20'h33333);
        tick(); chk("R2 sel_c_n high deselects", DESEL, 1'b0, 1'b1, 20'h00F00);
        drive(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 20'h44444);
        tick(); chk("R4 restart after deselect", BRD, 1'b1, 1'b1, 20'h44444);
        drive(1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 20'h55555);
        tick(); chk("R2 sel_a_n high with ctrl strobe", DESEL, 1'b0, 1'b1, 20'h44444);
    endtask

    initial begin
        t_reset();
        t_proc_read_linear();
        t_interleave();
        t_ctrl_strobe();
        t_sel_a_block();
        t_deselect();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        #2000000;
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run hung, actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

endmodule